// File: doc/BRIEF.md
# Operand addressing sequencer

This block resolves both operands of a two-operand instruction before execution. It takes a 16-bit instruction word and the address that word was fetched from. It decodes the source and destination addressing fields and walks through the required steps one at a time: extension-word fetches, effective-address formation, operand reads and post-increment of the source register. When it finishes, it presents the source value, the destination value, the destination location and an architectural cycle cost. Execution itself happens elsewhere. The block only raises a write-back request, tagged with the opcode, for the unit that performs the operation.

Two interfaces connect it to the rest of the core. The first is a register file with one combinational read port and one write port, used only for post-increment. The second is a single memory port. On that port a request holds its address until the memory answers with a ready pulse that carries the data. The block keeps the program counter internally, as a pointer to the next unconsumed instruction word, and it stands in for register 0. This lets three address forms reuse the general paths:
- Immediate operands are post-increment reads through that pointer.
- PC-relative operands are indexed on that pointer.
- Absolute operands are indexed on register 2, which reads as zero when used as an index base.

Top module: `opnd_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `mem_req` and `rf_we` are low.
- R2: The instruction fields are decoded as follows: opcode in bits 15..12 (returned on `wb_op`), source register in 11..8, destination form in bit 7 (0 register, 1 indexed), byte select in bit 6 (1 = byte), source form in 5..4 (00 register, 01 indexed, 10 indirect, 11 indirect with post-increment), destination register in 3..0.
- R3: In register source form, the source value is the register content. Register 0 reads as the address following the last consumed instruction word. A byte operation clears bits 15..8 of both operand values.
- R4: Indexed forms fetch one extension word at the current pointer. The address is base plus extension word. The base is the register, or the extension word's own address for register 0, or zero for register 2.
- R5: Indirect source form reads memory at the register content without an extension word, and leaves the register unchanged.
- R6: Post-increment source form reads at the register content and writes the register back plus 1 (byte) or plus 2 (word). This happens before the destination is evaluated, so a destination using the same register sees the new value.
- R7: Post-increment on register 0 is an immediate operand: the operand is the word following the consumed words (its low byte for byte operations), and the pointer always advances by 2.
- R8: Register destination gives `dst_is_mem`=0, `dst_addr` = register number and `dst_val` = register content. Indexed destination fetches an extension word, reads memory, and gives `dst_is_mem`=1, `dst_addr` = effective address and `dst_val` = the memory word.
- R9: `cycles` = 1 + source cost + destination cost. Source cost is 0 for register, 1 for indirect, post-increment or immediate, and 2 for indexed. Destination cost is 0 for register and 3 for indexed. `next_pc` is the instruction address plus 2 per consumed word.
- R10: A word access at an odd address, including an extension fetch, makes `align_err` high at `done` and keeps `wb_req` low. Byte accesses at any address raise no error.
- R11: A memory request keeps its address and size stable until `mem_ready`. Wait states delay the result but do not change it.
- R12: `done` and `wb_req` are one-cycle pulses. `start` is ignored while `busy` is high, and each accepted start produces exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving `instr` (accepted when idle) |
| instr | input | 16 | Instruction word |
| pc_in | input | W | Address of the instruction word |
| busy | output | 1 | Sequencer is working |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | W | Register file read data (combinational) |
| rf_we | output | 1 | Post-increment write enable |
| rf_waddr | output | 4 | Post-increment write address |
| rf_wdata | output | W | Post-increment write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | W | Memory byte address |
| mem_byte | output | 1 | Byte-sized access |
| mem_rdata | input | W | Memory read data (byte in bits 7..0) |
| mem_ready | input | 1 | Read data valid, request complete |
| done | output | 1 | Operands resolved (one cycle) |
| src_val | output | W | Source operand value |
| dst_val | output | W | Destination operand value |
| dst_addr | output | W | Destination register number or memory address |
| dst_is_mem | output | 1 | Destination lies in memory |
| align_err | output | 1 | Odd-address word access occurred |
| wb_req | output | 1 | Write-back request to execution |
| wb_op | output | 4 | Opcode field for the write-back |
| cycles | output | 4 | Architectural cycle cost |
| next_pc | output | W | Address after the last consumed word |

## Verification
Two of the block's functions can meet at a single clock edge: the post-increment write of the source register, and a later base read of that same register for an indexed destination. The bench sets this up with a word post-increment source and an indexed destination on the same register. It judges the outcome by the destination address, which must be built from the incremented value. A second overlap is the alignment check firing within an instruction that still produces a done. Odd-address word reads on either operand must suppress the write-back request in that same done cycle, while an odd byte access must not.

// File: rtl/opnd_seq.sv
`timescale 1ns/1ps
module opnd_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [15:0]  instr,
  input  logic [W-1:0] pc_in,
  output logic         busy,
  output logic [3:0]   rf_raddr,
  input  logic [W-1:0] rf_rdata,
  output logic         rf_we,
  output logic [3:0]   rf_waddr,
  output logic [W-1:0] rf_wdata,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  output logic         mem_byte,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready,
  output logic         done,
  output logic [W-1:0] src_val,
  output logic [W-1:0] dst_val,
  output logic [W-1:0] dst_addr,
  output logic         dst_is_mem,
  output logic         align_err,
  output logic         wb_req,
  output logic [3:0]   wb_op,
  output logic [3:0]   cycles,
  output logic [W-1:0] next_pc
);
  typedef enum logic [2:0] {IDLE, SRC, SEXT, SRD, DST, DEXT, DRD, FIN} st_t;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  st_t st;
  logic [15:0]  iq;
  logic [W-1:0] ptr, ea, sv, dv, da;
  logic         err;

  logic [3:0] sreg, dreg;
  logic [1:0] smode;
  logic       ad, bw, ext;
  logic [W-1:0] rv, base;
  logic [3:0] scost;

  assign sreg  = iq[11:8];
  assign ad    = iq[7];
  assign bw    = iq[6];
  assign smode = iq[5:4];
  assign dreg  = iq[3:0];

  function automatic logic [W-1:0] fit(input logic [W-1:0] v, input logic b);
    return b ? {{(W-8){1'b0}}, v[7:0]} : v;
  endfunction

  assign rf_raddr = (st == DST) ? dreg : sreg;
  assign rv   = (rf_raddr == 4'd0) ? ptr : rf_rdata;
  assign base = (rf_raddr == 4'd2) ? '0 : rv;

  assign rf_we    = (st == SRC) && (smode == 2'b11) && (sreg != 4'd0);
  assign rf_waddr = sreg;
  assign rf_wdata = rf_rdata + (bw ? ONE : TWO);

  assign ext      = (st == SEXT) || (st == DEXT);
  assign mem_req  = ext || (st == SRD) || (st == DRD);
  assign mem_addr = ext ? ptr : ea;
  assign mem_byte = mem_req && !ext && bw;

  always_comb begin
    case (smode)
      2'b00:   scost = 4'd0;
      2'b01:   scost = 4'd2;
      default: scost = 4'd1;
    endcase
  end

  assign cycles     = 4'd1 + scost + (ad ? 4'd3 : 4'd0);
  assign busy       = (st != IDLE);
  assign done       = (st == FIN);
  assign wb_req     = done && !err;
  assign wb_op      = iq[15:12];
  assign src_val    = sv;
  assign dst_val    = dv;
  assign dst_addr   = da;
  assign dst_is_mem = ad;
  assign align_err  = err;
  assign next_pc    = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IDLE;
      iq  <= '0;
      ptr <= '0;
      ea  <= '0;
      sv  <= '0;
      dv  <= '0;
      da  <= '0;
      err <= 1'b0;
    end else begin
      if (mem_req && !mem_byte && mem_addr[0]) err <= 1'b1;
      case (st)
        IDLE: if (start) begin
          iq  <= instr;
          ptr <= pc_in + TWO;
          err <= 1'b0;
          st  <= SRC;
        end
        SRC: case (smode)
          2'b00: begin sv <= fit(rv, bw); st <= DST; end
          2'b01: begin ea <= base; st <= SEXT; end
          2'b10: begin ea <= rv; st <= SRD; end
          default: begin
            ea <= rv;
            if (sreg == 4'd0) ptr <= ptr + TWO;
            st <= SRD;
          end
        endcase
        SEXT: if (mem_ready) begin
          ea  <= ea + mem_rdata;
          ptr <= ptr + TWO;
          st  <= SRD;
        end
        SRD: if (mem_ready) begin
          sv <= fit(mem_rdata, bw);
          st <= DST;
        end
        DST: if (!ad) begin
          dv <= fit(rv, bw);
          da <= {{(W-4){1'b0}}, dreg};
          st <= FIN;
        end else begin
          ea <= base;
          st <= DEXT;
        end
        DEXT: if (mem_ready) begin
          ea  <= ea + mem_rdata;
          ptr <= ptr + TWO;
          st  <= DRD;
        end
        DRD: if (mem_ready) begin
          dv <= fit(mem_rdata, bw);
          da <= ea;
          st <= FIN;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opnd_seq_chk.sv
`timescale 1ns/1ps
module opnd_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         rf_we,
  input logic         mem_req,
  input logic [W-1:0] mem_addr,
  input logic         mem_byte,
  input logic         mem_ready,
  input logic         done,
  input logic         align_err,
  input logic [3:0]   cycles
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_byte));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R10
  odd_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_byte && mem_addr[0] |=> align_err);

  // R9
  cycle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cycles >= 4'd1 && cycles <= 4'd6);

  // R6
  inc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy && !mem_req && !done);
endmodule

bind opnd_seq opnd_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .rf_we(rf_we),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_byte(mem_byte),
  .mem_ready(mem_ready), .done(done), .align_err(align_err), .cycles(cycles)
);

// File: tb/tb_opnd_seq.sv
`timescale 1ns/1ps
module tb_opnd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_in = 16'h0100;
  logic        busy, rf_we, mem_req, mem_byte, done, dst_is_mem, align_err, wb_req;
  logic [3:0]  rf_raddr, rf_waddr, wb_op, cycles;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, src_val, dst_val, dst_addr, next_pc;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  opnd_seq #(.W(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
    .busy(busy), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_byte(mem_byte), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .done(done), .src_val(src_val), .dst_val(dst_val),
    .dst_addr(dst_addr), .dst_is_mem(dst_is_mem), .align_err(align_err),
    .wb_req(wb_req), .wb_op(wb_op), .cycles(cycles), .next_pc(next_pc)
  );

  int checks = 0, errors = 0, ndone = 0, wait_n = 0, wcnt = 0;

  logic [15:0] rf [16];
  logic [7:0]  mem [1024];
  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  function automatic logic [15:0] rd16(input logic [15:0] a);
    return {mem[(a + 16'd1) & 16'h3ff], mem[a & 16'h3ff]};
  endfunction

  task automatic poke16(input logic [15:0] a, input logic [15:0] v);
    mem[a & 16'h3ff] = v[7:0];
    mem[(a + 16'd1) & 16'h3ff] = v[15:8];
  endtask

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt >= wait_n) begin
        mem_ready = 1'b1;
        mem_rdata = mem_byte ? {8'h00, mem[mem_addr & 16'h3ff]} : rd16(mem_addr);
        wcnt = 0;
      end else begin
        mem_ready = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ready = 1'b0;
      wcnt = 0;
    end
  end

  typedef struct {
    logic [15:0] src, dst, daddr, npc;
    logic        ismem, err;
    logic [3:0]  cyc, op;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  function automatic exp_t mk(input logic [15:0] s, d, da, np, input logic im, er,
                              input logic [3:0] cy, input string tg);
    exp_t x;
    x.src = s; x.dst = d; x.daddr = da; x.npc = np; x.ismem = im; x.err = er;
    x.cyc = cy; x.op = 4'h4; x.tag = tg;
    return x;
  endfunction

  function automatic logic [15:0] iw(input logic [3:0] s, input logic ad, bw,
                                     input logic [1:0] sm, input logic [3:0] d);
    return {4'h4, s, ad, bw, sm, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      ndone++;
      if (q.size() == 0) begin
        chk(1'b0, "R12 done without accepted start", 16'd1, 16'd0);
      end else begin
        e = q.pop_front();
        if (!e.err) begin
          chk(src_val == e.src, {e.tag, " src_val"}, src_val, e.src);
          chk(dst_val == e.dst, {e.tag, " dst_val"}, dst_val, e.dst);
        end
        chk(dst_addr == e.daddr, {e.tag, " dst_addr"}, dst_addr, e.daddr);
        chk(dst_is_mem == e.ismem, {e.tag, " R8 dst_is_mem"}, 16'(dst_is_mem), 16'(e.ismem));
        chk(cycles == e.cyc, {e.tag, " R9 cycles"}, 16'(cycles), 16'(e.cyc));
        chk(next_pc == e.npc, {e.tag, " R9 next_pc"}, next_pc, e.npc);
        chk(align_err == e.err, {e.tag, " R10 align_err"}, 16'(align_err), 16'(e.err));
        chk(wb_req == !e.err, {e.tag, " R10 wb_req"}, 16'(wb_req), 16'(!e.err));
        chk(wb_op == e.op, {e.tag, " R2 wb_op"}, 16'(wb_op), 16'(e.op));
      end
    end
  end

  task automatic issue(input logic [15:0] w, input exp_t x);
    q.push_back(x);
    @(negedge clk);
    instr = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'hA5;
    for (int i = 0; i < 16; i++) rf[i] = '0;
    rf[2] = 16'h1234; rf[4] = 16'h0200; rf[5] = 16'h0300;
    rf[6] = 16'h0011; rf[7] = 16'h0301; rf[9] = 16'hAB41;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req && !rf_we, "R1 reset outputs", {12'h0, busy, done, mem_req, rf_we}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we, "R1 after release", {12'h0, busy, done, mem_req, rf_we}, 16'h0);

    // R2 R3 register to register, word
    issue(iw(4'd6, 1'b0, 1'b0, 2'b00, 4'd9), mk(16'h0011, 16'hAB41, 16'd9, 16'h0102, 0, 0, 4'd1, "R2 R3 reg-reg"));
    // R3 byte clears upper half; register 2 in register form reads its content
    issue(iw(4'd2, 1'b0, 1'b1, 2'b00, 4'd9), mk(16'h0034, 16'h0041, 16'd9, 16'h0102, 0, 0, 4'd1, "R3 byte reg"));
    // R3 register 0 reads as the following word address
    issue(iw(4'd0, 1'b0, 1'b0, 2'b00, 4'd9), mk(16'h0102, 16'hAB41, 16'd9, 16'h0102, 0, 0, 4'd1, "R3 pc read"));
    // R5 indirect
    issue(iw(4'd4, 1'b0, 1'b0, 2'b10, 4'd9), mk(rd16(16'h0200), 16'hAB41, 16'd9, 16'h0102, 0, 0, 4'd2, "R5 indirect"));
    chk(rf[4] == 16'h0200, "R5 register unchanged", rf[4], 16'h0200);
    // R6 post-increment word, destination indexed on the same register
    poke16(16'h0102, 16'h0004);
    issue(iw(4'd5, 1'b1, 1'b0, 2'b11, 4'd5), mk(rd16(16'h0300), rd16(16'h0306), 16'h0306, 16'h0104, 1, 0, 4'd5, "R6 autoinc word"));
    chk(rf[5] == 16'h0302, "R6 increment by 2", rf[5], 16'h0302);
    // R6 R10 post-increment byte at odd address
    issue(iw(4'd7, 1'b0, 1'b1, 2'b11, 4'd9), mk({8'h00, mem[16'h0301]}, 16'h0041, 16'd9, 16'h0102, 0, 0, 4'd2, "R6 R10 byte odd"));
    chk(rf[7] == 16'h0302, "R6 increment by 1", rf[7], 16'h0302);
    // R7 immediate word and byte
    poke16(16'h0102, 16'h1357);
    issue(iw(4'd0, 1'b0, 1'b0, 2'b11, 4'd9), mk(16'h1357, 16'hAB41, 16'd9, 16'h0104, 0, 0, 4'd2, "R7 imm word"));
    poke16(16'h0102, 16'h2468);
    issue(iw(4'd0, 1'b0, 1'b1, 2'b11, 4'd9), mk(16'h0068, 16'h0041, 16'd9, 16'h0104, 0, 0, 4'd2, "R7 imm byte"));
    // R4 indexed source
    poke16(16'h0102, 16'h0006);
    issue(iw(4'd4, 1'b0, 1'b0, 2'b01, 4'd9), mk(rd16(16'h0206), 16'hAB41, 16'd9, 16'h0104, 0, 0, 4'd3, "R4 indexed"));
    // R4 R8 absolute to absolute (register 2 base reads zero)
    poke16(16'h0102, 16'h0220); poke16(16'h0104, 16'h0230);
    issue(iw(4'd2, 1'b1, 1'b0, 2'b01, 4'd2), mk(rd16(16'h0220), rd16(16'h0230), 16'h0230, 16'h0106, 1, 0, 4'd6, "R4 R8 absolute"));
    // R4 R11 PC-relative both sides with wait states
    wait_n = 2;
    poke16(16'h0102, 16'h0010); poke16(16'h0104, 16'h0020);
    issue(iw(4'd0, 1'b1, 1'b0, 2'b01, 4'd0), mk(rd16(16'h0112), rd16(16'h0124), 16'h0124, 16'h0106, 1, 0, 4'd6, "R4 R11 symbolic wait"));
    // R9 R8 immediate to indexed
    wait_n = 1;
    poke16(16'h0102, 16'h0005); poke16(16'h0104, 16'h0002);
    issue(iw(4'd0, 1'b1, 1'b0, 2'b11, 4'd4), mk(16'h0005, rd16(16'h0202), 16'h0202, 16'h0106, 1, 0, 4'd5, "R9 R8 imm to indexed"));
    // R10 odd word source and destination
    wait_n = 0;
    rf[7] = 16'h0303;
    issue(iw(4'd7, 1'b0, 1'b0, 2'b10, 4'd9), mk(16'h0, 16'h0, 16'd9, 16'h0102, 0, 1, 4'd2, "R10 odd word src"));
    poke16(16'h0102, 16'h0001);
    issue(iw(4'd6, 1'b1, 1'b0, 2'b00, 4'd4), mk(16'h0, 16'h0, 16'h0201, 16'h0104, 1, 1, 4'd4, "R10 odd word dst"));

    // R12 start held and changed while busy is ignored
    wait_n = 2;
    poke16(16'h0102, 16'h0010); poke16(16'h0104, 16'h0020);
    q.push_back(mk(rd16(16'h0112), rd16(16'h0124), 16'h0124, 16'h0106, 1, 0, 4'd6, "R12 busy start"));
    n0 = ndone;
    @(negedge clk);
    instr = iw(4'd0, 1'b1, 1'b0, 2'b01, 4'd0);
    start = 1'b1;
    @(negedge clk);
    instr = iw(4'd6, 1'b0, 1'b0, 2'b00, 4'd9);
    repeat (2) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ndone == n0 + 1, "R12 one done per start", 16'(ndone - n0), 16'd1);
    chk(!busy, "R12 idle after done", 16'(busy), 16'd0);
    chk(q.size() == 0, "R12 all results seen", 16'(q.size()), 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule